// File: doc/BRIEF.md
# Load Miss Address File with Block Merging

This block tracks the outstanding load misses of a data cache. Each miss carries a byte address and the tag of the load-queue slot that missed. The block reduces the address to a 64-byte block number and compares it with every pending entry. A miss to a block that is already pending does not take a new entry. Its load tag is recorded in that entry's waiting mask, and no second memory request is made.

A miss to a new block takes the lowest-numbered free entry. The entry is then offered on a valid/ready request port. Unissued entries go out oldest first, by allocation order and not by slot number.

When the memory side returns a fill for a block, the matching entry is freed. On the next cycle, for exactly one cycle, the block presents the waiting mask, so every load that waited on that block wakes together. When all entries are in use, `full` is raised. A miss that cannot merge is then stalled, and the requester must hold it.

Top module: `miss_merge_file`

## Requirements
- R1: After reset there are no pending entries: `req_valid`, `full` and `wake_valid` are 0.
- R2: A miss whose block `miss_addr[ADDR_W-1:6]` matches no pending entry is allocated. From the next cycle it is offered as `req_valid`=1 with that block on `req_block`, provided no older unissued entry exists.
- R3: A miss whose address bits above bit 5 equal those of a pending entry allocates nothing and produces no new request. Its load tag sets bit `miss_tag` of that entry's waiting mask.
- R4: While `req_valid` is 1 and `req_ready` is 0, the request and its block stay unchanged, unless a fill removes that entry. An entry accepted with `req_valid`&`req_ready` is never offered again.
- R5: Among unissued entries, the one allocated earliest is offered first, whatever slot it occupies.
- R6: `full` is 1 exactly when all 8 entries are pending. In that state a non-merging miss raises `miss_stall` in the same cycle and is not recorded. A merging miss is still accepted with `miss_stall`=0.
- R7: A fill whose block matches a pending entry frees that entry. On the following cycle it gives `wake_valid`=1 and a `wake_mask` that holds one bit per merged load tag (bit n for tag n).
- R8: A fill matching no pending entry changes nothing and gives `wake_valid`=0 on the next cycle.
- R9: A miss and a fill to the same block in the same cycle do not merge. The miss gets a fresh entry that is requested again.
- R10: `wake_valid` lasts one cycle per fill. With no fill, it is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_addr | input | ADDR_W (40) | Byte address of the miss |
| miss_tag | input | TAG_W (4) | Load-queue tag of the missing load |
| miss_stall | output | 1 | Miss cannot be accepted this cycle; hold it |
| fill_valid | input | 1 | Fill data returned for a block |
| fill_block | input | BLK_W (34) | Block number of the fill |
| req_valid | output | 1 | Downstream block request offered |
| req_block | output | BLK_W (34) | Block number requested |
| req_ready | input | 1 | Downstream accepts the request |
| full | output | 1 | All entries pending |
| wake_valid | output | 1 | Wake-up mask is valid this cycle |
| wake_mask | output | NTAGS (16) | One bit per load tag to wake |

## Verification
`miss_stall` is combinational on the current miss and the entry state. The bench samples it one nanosecond after driving, before the clock edge that would record the miss. `req_valid`, `req_block` and `full` come from entry registers, so they reflect a miss, fill or handshake one edge later. `wake_valid` and `wake_mask` are registered from the fill compare, so they appear one edge after the fill and fall again an edge after that. Every check of these outputs is taken one nanosecond after the edge that is meant to update them, and before the next input change.

// File: rtl/mmf_pkg.sv
`timescale 1ns/1ps
package mmf_pkg;
  localparam int unsigned MMF_ADDR_W  = 40;
  localparam int unsigned MMF_OFS_W   = 6;
  localparam int unsigned MMF_ENTRIES = 8;
  localparam int unsigned MMF_NTAGS   = 16;

  // Block number of a byte address: drop the offset bits.
  function automatic logic [MMF_ADDR_W-1:0] block_of(input logic [MMF_ADDR_W-1:0] a,
                                                     input int unsigned ofs);
    return a >> ofs;
  endfunction

  // One-hot decode of a small index into a 64-bit vector.
  function automatic logic [63:0] tag_bit(input int unsigned t);
    logic [63:0] v;
    v = '0;
    v[t] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/mmf_cam.sv
`timescale 1ns/1ps
// Parallel compare of one probe block against every entry.
module mmf_cam #(
  parameter int unsigned N  = 8,
  parameter int unsigned BW = 34
) (
  input  logic [N-1:0][BW-1:0] blk,
  input  logic [N-1:0]         vld,
  input  logic [BW-1:0]        probe,
  output logic [N-1:0]         hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = vld[i] && (blk[i] == probe);
  end
endmodule

// File: rtl/mmf_pick_free.sv
`timescale 1ns/1ps
// Lowest-numbered free slot, one-hot.
module mmf_pick_free #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] free_vec,
  output logic [N-1:0] pick,
  output logic         any
);
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) pick = N'(1) << i;
    end
  end
  assign any = |free_vec;
endmodule

// File: rtl/mmf_age.sv
`timescale 1ns/1ps
// Age matrix: older_q[i][j] set means slot i was allocated before slot j.
module mmf_age #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_vec,
  input  logic [N-1:0] cand,
  output logic [N-1:0] oldest
);
  logic [N-1:0][N-1:0] older_q;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        assign older_q[i][j] = 1'b0;
      end else begin : g_cell
        logic cell_q;
        always_ff @(posedge clk) begin
          if (!rst_n)            cell_q <= 1'b0;
          else if (alloc_vec[i]) cell_q <= 1'b0;
          else if (alloc_vec[j]) cell_q <= 1'b1;
        end
        assign older_q[i][j] = cell_q;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      oldest[i] = cand[i];
      for (int j = 0; j < N; j++) begin
        if (cand[j] && older_q[j][i]) oldest[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/miss_merge_file.sv
`timescale 1ns/1ps
module miss_merge_file #(
  parameter  int unsigned ADDR_W  = mmf_pkg::MMF_ADDR_W,
  parameter  int unsigned OFS_W   = mmf_pkg::MMF_OFS_W,
  parameter  int unsigned ENTRIES = mmf_pkg::MMF_ENTRIES,
  parameter  int unsigned NTAGS   = mmf_pkg::MMF_NTAGS,
  localparam int unsigned TAG_W   = $clog2(NTAGS),
  localparam int unsigned BLK_W   = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [TAG_W-1:0]  miss_tag,
  output logic              miss_stall,
  input  logic              fill_valid,
  input  logic [BLK_W-1:0]  fill_block,
  output logic              req_valid,
  output logic [BLK_W-1:0]  req_block,
  input  logic              req_ready,
  output logic              full,
  output logic              wake_valid,
  output logic [NTAGS-1:0]  wake_mask
);
  localparam int unsigned N = ENTRIES;

  // Entry state
  logic [N-1:0]            valid_q, issued_q;
  logic [N-1:0][BLK_W-1:0] blk_q;
  logic [N-1:0][NTAGS-1:0] mask_q;
  logic                    wake_valid_q;
  logic [NTAGS-1:0]        wake_mask_q;

  // Named internal events
  logic [BLK_W-1:0] miss_blk;
  logic [N-1:0]     miss_hit_raw, fill_hit, merge_vec, free_vec, free_pick;
  logic [N-1:0]     alloc_vec, cand, oldest, issue_vec;
  logic             merge_hit, fill_any, any_free, alloc_need, alloc_fire, req_fire;
  logic [NTAGS-1:0] tag_onehot, leaving_mask;

  assign miss_blk   = BLK_W'(mmf_pkg::block_of(mmf_pkg::MMF_ADDR_W'(miss_addr), OFS_W));
  assign tag_onehot = NTAGS'(mmf_pkg::tag_bit(int'(miss_tag)));

  mmf_cam #(.N(N), .BW(BLK_W)) u_miss_cam (
    .blk(blk_q), .vld(valid_q), .probe(miss_blk), .hit(miss_hit_raw));

  mmf_cam #(.N(N), .BW(BLK_W)) u_fill_cam (
    .blk(blk_q), .vld(valid_q), .probe(fill_block), .hit(fill_hit));

  // An entry being filled this cycle cannot absorb a new miss.
  assign merge_vec  = fill_valid ? (miss_hit_raw & ~fill_hit) : miss_hit_raw;
  assign merge_hit  = miss_valid && (|merge_vec);
  assign fill_any   = fill_valid && (|fill_hit);
  assign free_vec   = ~valid_q;

  mmf_pick_free #(.N(N)) u_pick (.free_vec(free_vec), .pick(free_pick), .any(any_free));

  assign alloc_need = miss_valid && !merge_hit;
  assign alloc_fire = alloc_need && any_free;
  assign alloc_vec  = alloc_fire ? free_pick : '0;
  assign miss_stall = alloc_need && !any_free;
  assign full       = &valid_q;

  // Downstream request, oldest unissued first
  assign cand = valid_q & ~issued_q;

  mmf_age #(.N(N)) u_age (
    .clk(clk), .rst_n(rst_n), .alloc_vec(alloc_vec), .cand(cand), .oldest(oldest));

  always_comb begin
    req_block = '0;
    for (int i = 0; i < N; i++) begin
      if (oldest[i]) req_block = req_block | blk_q[i];
    end
  end
  assign req_valid = |cand;
  assign req_fire  = req_valid && req_ready;
  assign issue_vec = req_fire ? oldest : '0;

  // Waiting mask of the entry a fill releases
  always_comb begin
    leaving_mask = '0;
    for (int i = 0; i < N; i++) begin
      if (fill_valid && fill_hit[i]) leaving_mask = leaving_mask | mask_q[i];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i]  <= 1'b0;
        issued_q[i] <= 1'b0;
        blk_q[i]    <= '0;
        mask_q[i]   <= '0;
      end else if (fill_valid && fill_hit[i]) begin
        valid_q[i]  <= 1'b0;
        issued_q[i] <= 1'b0;
        mask_q[i]   <= '0;
      end else if (alloc_vec[i]) begin
        valid_q[i]  <= 1'b1;
        issued_q[i] <= 1'b0;
        blk_q[i]    <= miss_blk;
        mask_q[i]   <= tag_onehot;
      end else begin
        if (miss_valid && merge_vec[i]) mask_q[i] <= mask_q[i] | tag_onehot;
        if (issue_vec[i])               issued_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_valid_q <= 1'b0;
      wake_mask_q  <= '0;
    end else begin
      wake_valid_q <= fill_any;
      wake_mask_q  <= fill_any ? leaving_mask : '0;
    end
  end

  assign wake_valid = wake_valid_q;
  assign wake_mask  = wake_mask_q;
endmodule

// File: rtl/mmf_checker.sv
`timescale 1ns/1ps
module mmf_checker #(
  parameter int unsigned N     = 8,
  parameter int unsigned BLK_W = 34,
  parameter int unsigned NTAGS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic             miss_stall,
  input logic             fill_valid,
  input logic [BLK_W-1:0] fill_block,
  input logic             req_valid,
  input logic [BLK_W-1:0] req_block,
  input logic             req_ready,
  input logic             full,
  input logic             wake_valid,
  input logic [NTAGS-1:0] wake_mask,
  input logic [N-1:0]     valid_q,
  input logic             merge_hit,
  input logic             fill_any,
  input logic             alloc_fire
);
  // R1: leaving reset, nothing is pending
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> (!req_valid && !full && !wake_valid));

  // R2: a new-block allocation without a fill grows the file by one
  a_r2_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !fill_any) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

  // R3: a merged miss adds no entry
  a_r3_merge_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_hit && !fill_valid) |=> ($countones(valid_q) == $past($countones(valid_q))));

  // R4: a stalled request holds unless its block is filled
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !(fill_valid && fill_block == req_block))
      |=> (req_valid && $stable(req_block)));

  // R6: stalls happen only when the file is full
  a_r6_stall_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_stall) |-> full);

  // R7: a wake follows a fill and names at least one load
  a_r7_wake_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> ($past(fill_valid) && (wake_mask != '0)));

  // R10: without a fill, the wake drops on the next cycle
  a_r10_wake_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |=> !wake_valid);
endmodule

bind miss_merge_file mmf_checker #(.N(ENTRIES), .BLK_W(BLK_W), .NTAGS(NTAGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_stall(miss_stall),
  .fill_valid(fill_valid), .fill_block(fill_block), .req_valid(req_valid),
  .req_block(req_block), .req_ready(req_ready), .full(full), .wake_valid(wake_valid),
  .wake_mask(wake_mask), .valid_q(valid_q), .merge_hit(merge_hit),
  .fill_any(fill_any), .alloc_fire(alloc_fire));

// File: tb/sim_miss_merge_file.sv
`timescale 1ns/1ps
module sim_miss_merge_file;
  localparam int ADDR_W = 40, BLK_W = 34, TAG_W = 4, NTAGS = 16;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              miss_valid = 1'b0, fill_valid = 1'b0, req_ready = 1'b0;
  logic [ADDR_W-1:0] miss_addr = '0;
  logic [TAG_W-1:0]  miss_tag = '0;
  logic [BLK_W-1:0]  fill_block = '0;
  logic              miss_stall, req_valid, full, wake_valid;
  logic [BLK_W-1:0]  req_block;
  logic [NTAGS-1:0]  wake_mask;

  always #4 clk = ~clk;  // 125 MHz

  miss_merge_file u0 (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic stall_seen;

  typedef struct packed {
    logic mv; logic [15:0] blk; logic [5:0] off; logic [3:0] tag;
    logic fv; logic [15:0] fblk; logic rdy;
    logic e_stall; logic e_rv; logic [15:0] e_rblk; logic e_full;
    logic e_wv; logic [15:0] e_wmask;
  } vec_t;

  localparam vec_t TABLE [12] = '{
    '{1'b1,16'h10,6'h08,4'd1, 1'b0,16'h0, 1'b0, 1'b0,1'b1,16'h10,1'b0,1'b0,16'h0},    // R2
    '{1'b1,16'h10,6'h30,4'd3, 1'b0,16'h0, 1'b0, 1'b0,1'b1,16'h10,1'b0,1'b0,16'h0},    // R3 merge
    '{1'b1,16'h20,6'h00,4'd2, 1'b0,16'h0, 1'b1, 1'b0,1'b1,16'h20,1'b0,1'b0,16'h0},    // R4 issue
    '{1'b1,16'h30,6'h11,4'd5, 1'b0,16'h0, 1'b0, 1'b0,1'b1,16'h20,1'b0,1'b0,16'h0},    // R4 hold
    '{1'b0,16'h0,6'h00,4'd0,  1'b0,16'h0, 1'b1, 1'b0,1'b1,16'h30,1'b0,1'b0,16'h0},    // R4
    '{1'b0,16'h0,6'h00,4'd0,  1'b1,16'h10,1'b0, 1'b0,1'b1,16'h30,1'b0,1'b1,16'h000A}, // R7
    '{1'b0,16'h0,6'h00,4'd0,  1'b0,16'h0, 1'b0, 1'b0,1'b1,16'h30,1'b0,1'b0,16'h0},    // R10
    '{1'b0,16'h0,6'h00,4'd0,  1'b1,16'h55,1'b0, 1'b0,1'b1,16'h30,1'b0,1'b0,16'h0},    // R8
    '{1'b0,16'h0,6'h00,4'd0,  1'b0,16'h0, 1'b1, 1'b0,1'b0,16'h0, 1'b0,1'b0,16'h0},    // R4
    '{1'b1,16'h20,6'h04,4'd7, 1'b1,16'h20,1'b0, 1'b0,1'b1,16'h20,1'b0,1'b1,16'h0004}, // R9
    '{1'b0,16'h0,6'h00,4'd0,  1'b1,16'h30,1'b1, 1'b0,1'b0,16'h0, 1'b0,1'b1,16'h0020}, // R7
    '{1'b0,16'h0,6'h00,4'd0,  1'b1,16'h20,1'b0, 1'b0,1'b0,16'h0, 1'b0,1'b1,16'h0080}  // R9
  };

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle's inputs, capture the stall before the edge, return 1ns after it.
  task automatic step(input logic mv, input logic [15:0] blk, input logic [5:0] off,
                      input logic [3:0] tag, input logic fv, input logic [15:0] fblk,
                      input logic rdy);
    @(negedge clk);
    miss_valid = mv; miss_addr = {18'h0, blk, off}; miss_tag = tag;
    fill_valid = fv; fill_block = {18'h0, fblk}; req_ready = rdy;
    #1 stall_seen = miss_stall;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 16'h0, 6'h0, 4'd0, 1'b0, 16'h0, 1'b0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "req_valid", req_valid, 0);
    check("R1", "full", full, 0);
    check("R1", "wake_valid", wake_valid, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < 12; k++) begin
      step(TABLE[k].mv, TABLE[k].blk, TABLE[k].off, TABLE[k].tag,
           TABLE[k].fv, TABLE[k].fblk, TABLE[k].rdy);
      check("R6", $sformatf("row%0d stall", k), stall_seen, TABLE[k].e_stall);
      check("R2", $sformatf("row%0d req_valid", k), req_valid, TABLE[k].e_rv);
      if (TABLE[k].e_rv)
        check("R5", $sformatf("row%0d req_block", k), req_block, TABLE[k].e_rblk);
      check("R6", $sformatf("row%0d full", k), full, TABLE[k].e_full);
      check("R7", $sformatf("row%0d wake_valid", k), wake_valid, TABLE[k].e_wv);
      if (TABLE[k].e_wv)
        check("R7", $sformatf("row%0d wake_mask", k), wake_mask, TABLE[k].e_wmask);
    end

    // R5: age, not slot number, decides the order
    step(1'b1, 16'h200, 6'h0, 4'd1, 1'b0, 16'h0, 1'b0);
    step(1'b1, 16'h201, 6'h0, 4'd2, 1'b0, 16'h0, 1'b0);
    step(1'b1, 16'h202, 6'h0, 4'd3, 1'b0, 16'h0, 1'b0);
    step(1'b0, 16'h0, 6'h0, 4'd0, 1'b1, 16'h200, 1'b0);   // frees slot 0
    check("R7", "unissued fill wake", wake_mask, 16'h0002);
    step(1'b1, 16'h203, 6'h0, 4'd4, 1'b0, 16'h0, 1'b0);   // reuses slot 0
    check("R5", "oldest first", req_block, 34'h201);
    step(1'b0, 16'h0, 6'h0, 4'd0, 1'b0, 16'h0, 1'b1);
    check("R5", "second", req_block, 34'h202);
    step(1'b0, 16'h0, 6'h0, 4'd0, 1'b0, 16'h0, 1'b1);
    check("R5", "youngest last", req_block, 34'h203);
    step(1'b0, 16'h0, 6'h0, 4'd0, 1'b0, 16'h0, 1'b1);
    check("R4", "no reissue", req_valid, 0);
    step(1'b0, 16'h0, 6'h0, 4'd0, 1'b1, 16'h201, 1'b0);
    step(1'b0, 16'h0, 6'h0, 4'd0, 1'b1, 16'h202, 1'b0);
    step(1'b0, 16'h0, 6'h0, 4'd0, 1'b1, 16'h203, 1'b0);

    // R6: fill the file, stall, merge while full
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 16'h100 + 16'(i), 6'h0, 4'(i), 1'b0, 16'h0, 1'b0);
      check("R6", $sformatf("full after %0d", i + 1), full, (i == 7) ? 1 : 0);
    end
    step(1'b1, 16'h1FF, 6'h0, 4'd9, 1'b0, 16'h0, 1'b0);
    check("R6", "stall when full", stall_seen, 1);
    check("R6", "stalled miss not queued", req_block, 34'h100);
    step(1'b1, 16'h103, 6'h22, 4'd12, 1'b0, 16'h0, 1'b0);
    check("R6", "merge while full", stall_seen, 0);
    step(1'b0, 16'h0, 6'h0, 4'd0, 1'b1, 16'h103, 1'b0);
    check("R7", "wake mask merged", wake_mask, 16'h1008);
    check("R7", "entry freed", full, 0);
    idle();
    check("R10", "wake one cycle", wake_valid, 0);
    step(1'b1, 16'h1FF, 6'h0, 4'd9, 1'b0, 16'h0, 1'b0);
    check("R6", "retry accepted", stall_seen, 0);
    for (int i = 0; i < 8; i++) begin
      automatic logic [15:0] exp_b = (i < 3) ? 16'h100 + 16'(i)
                                   : (i < 7) ? 16'h101 + 16'(i) : 16'h1FF;
      check("R5", $sformatf("drain %0d", i), req_block, {18'h0, exp_b});
      step(1'b0, 16'h0, 6'h0, 4'd0, 1'b0, 16'h0, 1'b1);
    end
    check("R4", "drained", req_valid, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule